// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target (256 x 8)

This block is the target side of a two-wire serial memory. It holds 256 bytes of eight bits each, all set to FFh when reset is released. A bus master addresses it with a device select byte. It then either loads an address and writes one or more data bytes, or reads bytes starting from an internal address counter. SCL and SDA arrive asynchronously and are sampled on the system clock. The block pulls SDA low through an open-drain enable and never drives it high.

Write data is collected in a page buffer and is not copied into the array straight away. The STOP that closes a write starts a timed internal write cycle, and the buffered bytes are committed at the end of that cycle. While the cycle runs, the block acknowledges no device select. A master can therefore poll it with repeated device selects until one is acknowledged. The address counter persists between transfers. A current-address read continues from where the last access left it. A random read loads the counter with an address-only write, then issues a repeated START and a read select.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset every one of the 256 locations reads FFh, and `sda_oe` is low.
- R2: A device select byte is acknowledged only when its bits 7:4 equal 1010 and its bits 3:1 equal `CHIP_SEL`. Bit 0 selects the direction (1 = read, 0 = write). A byte that does not match leaves SDA released for the acknowledge bit and for the rest of the transfer.
- R3: A byte write is a write select, one address byte and one data byte, each acknowledged, followed by STOP. Once the write cycle ends, the addressed location reads back the data byte.
- R4: In a page write the data bytes go to successive addresses. Only the low `PG_W` address bits (4 by default, a 16-byte page) advance, wrapping within the page while the upper bits stay fixed. All bytes are committed together when the write cycle ends.
- R5: A repeated START that arrives after write data and before any STOP discards the buffered data. No write cycle starts and the array is unchanged.
- R6: The write cycle starts at a STOP that follows at least one accepted data byte and lasts `WRITE_CYCLES` clock cycles. During it no device select is acknowledged; after it a matching device select is acknowledged again.
- R7: A current-address read returns the byte at the address counter. The counter advances by one after each byte read and wraps from FFh to 00h.
- R8: A random read is a write select and an address byte, then a repeated START and a read select. It returns the byte at the loaded address.
- R9: During a read, an acknowledge from the master (SDA low) makes the block send the next byte. A not-acknowledge makes it release SDA and wait for STOP or START.
- R10: `sda_oe` rises only while SCL is low, and a data bit that the block drives stays stable for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND result) |
| sda_oe | output | 1 | Pulls SDA low when high; SDA is released when low |

## Verification
Each acknowledge or read data bit appears on `sda_oe` `SYNC_STAGES`+2 clock cycles after SCL falls on the pin: two synchronizer flops, one event register and the protocol register. The bench holds every SCL phase for ten clock cycles and samples SDA ten cycles after SCL rises, well past that point, and samples a second time before SCL falls to confirm the bit is stable. The write cycle ends `WRITE_CYCLES` cycles after the STOP is detected. The bench does not wait a fixed time for it. It polls with device selects, expects the first poll to go unacknowledged, and reads the data back only after a poll has been acknowledged.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [3:0]  FAMILY_CODE = 4'b1010;

    // Transaction phase of the protocol engine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK
    } proto_st_e;

    // Bus events derived from the synchronized pins, one clock wide.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // True when a received select byte names this target.
    function automatic logic devsel_hit(input logic [BYTE_W-1:0] sel,
                                        input logic [2:0]        chip);
        return (sel[7:4] == FAMILY_CODE) && (sel[3:1] == chip);
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    output eep_pkg::bus_ev_t ev
);
    import eep_pkg::*;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_s, sda_s;
    logic scl_d, sda_d;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            ev       <= '0;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
            ev.rise  <= scl_s & ~scl_d;
            ev.fall  <= ~scl_s & scl_d;
            ev.start <= scl_s & scl_d & sda_d & ~sda_s;
            ev.stop  <= scl_s & scl_d & ~sda_d & sda_s;
            ev.sda   <= sda_s;
        end
    end

endmodule

// File: rtl/eep_proto.sv
module eep_proto #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned PG_W     = 4,
    parameter logic [2:0]  CHIP_SEL = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  eep_pkg::bus_ev_t  ev,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pb_open,
    output logic [ADDR_W-PG_W-1:0] pb_base,
    output logic              pb_wr,
    output logic [PG_W-1:0]   pb_off,
    output logic [7:0]        pb_data,
    output logic              commit_go,
    output logic              sda_oe
);
    import eep_pkg::*;

    proto_st_e         st;
    logic [3:0]        bit_cnt;
    logic [7:0]        sr;
    logic [ADDR_W-1:0] cnt;
    logic              rw_q;
    logic              pending;
    logic              mack;
    logic              byte_done;

    assign rd_addr   = cnt;
    assign byte_done = ev.fall && (bit_cnt == 4'd8);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bit_cnt   <= '0;
            sr        <= '0;
            cnt       <= '0;
            rw_q      <= 1'b0;
            pending   <= 1'b0;
            mack      <= 1'b1;
            sda_oe    <= 1'b0;
            pb_open   <= 1'b0;
            pb_base   <= '0;
            pb_wr     <= 1'b0;
            pb_off    <= '0;
            pb_data   <= '0;
            commit_go <= 1'b0;
        end else begin
            pb_open   <= 1'b0;
            pb_wr     <= 1'b0;
            commit_go <= 1'b0;
            if (ev.start) begin
                // a restart abandons any write data not yet closed by STOP
                st      <= ST_DEVSEL;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
            end else if (ev.stop) begin
                st        <= ST_IDLE;
                sda_oe    <= 1'b0;
                commit_go <= pending;
                pending   <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEVSEL: begin
                        if (ev.rise && bit_cnt < 4'd8) begin
                            sr      <= {sr[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (devsel_hit(sr, CHIP_SEL) && !busy) begin
                                sda_oe <= 1'b1;
                                rw_q   <= sr[0];
                                st     <= ST_DEV_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (ev.rise && bit_cnt < 4'd8) begin
                            sr      <= {sr[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            cnt     <= sr[ADDR_W-1:0];
                            pb_open <= 1'b1;
                            pb_base <= sr[ADDR_W-1:PG_W];
                            st      <= ST_ADDR_ACK;
                        end
                    end
                    ST_WDATA: begin
                        if (ev.rise && bit_cnt < 4'd8) begin
                            sr      <= {sr[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            pb_wr   <= 1'b1;
                            pb_off  <= cnt[PG_W-1:0];
                            pb_data <= sr;
                            cnt[PG_W-1:0] <= cnt[PG_W-1:0] + 1'b1;
                            pending <= 1'b1;
                            st      <= ST_WDATA_ACK;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.fall) begin
                            if (rw_q) begin
                                sr      <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                cnt     <= cnt + 1'b1;
                                bit_cnt <= '0;
                                st      <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.rise && bit_cnt < 4'd8) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_RD_ACK;
                        end else if (ev.fall) begin
                            sr     <= {sr[6:0], 1'b0};
                            sda_oe <= ~sr[6];
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            mack <= ev.sda;
                        end else if (ev.fall) begin
                            if (!mack) begin
                                sr      <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                cnt     <= cnt + 1'b1;
                                bit_cnt <= '0;
                                st      <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PG_W         = 4,
    parameter int unsigned WRITE_CYCLES = 5000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    input  logic                   pb_open,
    input  logic [ADDR_W-PG_W-1:0] pb_base,
    input  logic                   pb_wr,
    input  logic [PG_W-1:0]        pb_off,
    input  logic [7:0]             pb_data,
    input  logic                   commit_go,
    output logic                   busy
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PAGE  = 1 << PG_W;
    localparam int unsigned TMR_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);

    logic [7:0]            mem     [DEPTH];
    logic [7:0]            pg_data [PAGE];
    logic [PAGE-1:0]       pg_valid;
    logic [ADDR_W-PG_W-1:0] pg_base;
    logic [TMR_W-1:0]      tmr;
    logic                  finish;

    assign rd_data = mem[rd_addr];
    assign finish  = busy && (tmr == '0);

    // page buffer: collects data until the write cycle ends
    always_ff @(posedge clk) begin
        if (rst) begin
            pg_valid <= '0;
            pg_base  <= '0;
        end else if (finish) begin
            pg_valid <= '0;
        end else begin
            if (pb_open) begin
                pg_base  <= pb_base;
                pg_valid <= '0;
            end
            if (pb_wr) begin
                pg_valid[pb_off] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pb_wr) begin
            pg_data[pb_off] <= pb_data;
        end
    end

    // write-cycle timer
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (commit_go) begin
            busy <= 1'b1;
            tmr  <= TMR_LOAD;
        end else if (finish) begin
            busy <= 1'b0;
        end else if (busy) begin
            tmr <= tmr - 1'b1;
        end
    end

    // storage array: erased to all ones, updated only when a cycle ends
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (finish) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pg_valid[i]) begin
                    mem[{pg_base, PG_W'(i)}] <= pg_data[i];
                end
            end
        end
    end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PG_W         = 4,
    parameter int unsigned WRITE_CYCLES = 5000,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter logic [2:0]  CHIP_SEL     = 3'b000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import eep_pkg::*;

    bus_ev_t                 ev;
    logic                    busy;
    logic [7:0]              rd_data;
    logic [ADDR_W-1:0]       rd_addr;
    logic                    pb_open;
    logic [ADDR_W-PG_W-1:0]  pb_base;
    logic                    pb_wr;
    logic [PG_W-1:0]         pb_off;
    logic [7:0]              pb_data;
    logic                    commit_go;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_proto #(.ADDR_W(ADDR_W), .PG_W(PG_W), .CHIP_SEL(CHIP_SEL)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .pb_open   (pb_open),
        .pb_base   (pb_base),
        .pb_wr     (pb_wr),
        .pb_off    (pb_off),
        .pb_data   (pb_data),
        .commit_go (commit_go),
        .sda_oe    (sda_oe)
    );

    eep_store #(.ADDR_W(ADDR_W), .PG_W(PG_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pb_open   (pb_open),
        .pb_base   (pb_base),
        .pb_wr     (pb_wr),
        .pb_off    (pb_off),
        .pb_data   (pb_data),
        .commit_go (commit_go),
        .busy      (busy)
    );

endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
    parameter int unsigned WRITE_CYCLES = 5000
) (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe,
    input logic busy,
    input logic commit_go,
    input logic pb_wr
);
    logic        rst_q;
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || commit_go) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_release_chk: assert (!sda_oe) else $error("sda driven after reset");
        end
    end

    // R10
    pull_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R6
    commit_start_chk: assert property (@(posedge clk) disable iff (rst)
        commit_go |=> busy);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == WRITE_CYCLES));

    // R4
    fill_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pb_wr |-> !busy);

endmodule

bind i2c_eeprom_target eep_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .commit_go (commit_go),
    .pb_wr     (pb_wr)
);

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;

    localparam int unsigned WC = 600;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic done = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] rbuf [16];

    assign sda_bus = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_eeprom_target #(.WRITE_CYCLES(WC)) dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold();
            scl = 1'b1; hold(); hold();
            scl = 1'b0; hold();
        end
        m_sda = 1'b1; hold();
        scl = 1'b1; hold();
        acked = ~sda_bus;
        hold();
        scl = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic stable;
        stable = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl = 1'b1; hold();
            b[i] = sda_bus;
            hold();
            if (sda_bus !== b[i]) stable = 1'b0;
            scl = 1'b0;
        end
        // R10: each driven bit held through SCL high
        chk("R10", stable, 1'b1);
        hold();
        m_sda = give_ack ? 1'b0 : 1'b1; hold();
        scl = 1'b1; hold(); hold();
        scl = 1'b0; hold();
        m_sda = 1'b1;
    endtask

    task automatic poll_ready(output int polls, output logic first_ack);
        logic a;
        polls = 0;
        first_ack = 1'b0;
        for (int k = 0; k < 40; k++) begin
            bus_start();
            send_byte(8'hA0, a);
            bus_stop();
            polls++;
            if (k == 0) first_ack = a;
            if (a) break;
        end
        chk("R6", a, 1'b1);
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [7:0] d0, input int n);
        logic a;
        int polls;
        logic first;
        bus_start();
        send_byte(8'hA0, a); chk("R3", a, 1'b1);
        send_byte(addr, a);  chk("R3", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(d0 + 8'(i), a);
            chk("R3", a, 1'b1);
        end
        bus_stop();
        poll_ready(polls, first);
        // R6: first poll lands inside the write cycle
        chk("R6", first, 1'b0);
    endtask

    task automatic rand_read(input logic [7:0] addr, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, a); chk("R8", a, 1'b1);
        send_byte(addr, a);  chk("R8", a, 1'b1);
        bus_start();
        send_byte(8'hA1, a); chk("R8", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        // R9: released after not-acknowledge
        chk("R9", sda_oe, 1'b0);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] b);
        logic a;
        bus_start();
        send_byte(8'hA1, a); chk("R7", a, 1'b1);
        recv_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1", sda_oe, 1'b0);
        cur_read(b);
        chk("R1", b, 8'hFF);
    endtask

    task automatic t_select();
        logic a;
        bus_start(); send_byte(8'hA2, a); chk("R2", a, 1'b0);
        chk("R2", sda_oe, 1'b0); bus_stop();
        bus_start(); send_byte(8'hB0, a); chk("R2", a, 1'b0); bus_stop();
        bus_start(); send_byte(8'hA0, a); chk("R2", a, 1'b1); bus_stop();
    endtask

    task automatic t_byte_write();
        write_seq(8'h00, 8'hC3, 1);
        write_seq(8'h01, 8'h11, 1);
        rand_read(8'h00, 2);
        chk("R3", rbuf[0], 8'hC3);
        chk("R3", rbuf[1], 8'h11);
    endtask

    task automatic t_wrap();
        logic [7:0] b;
        rand_read(8'hFF, 1);
        chk("R8", rbuf[0], 8'hFF);
        cur_read(b);
        chk("R7", b, 8'hC3);
        cur_read(b);
        chk("R7", b, 8'h11);
    endtask

    task automatic t_page();
        logic [7:0] exp;
        write_seq(8'h3C, 8'hA1, 6);
        rand_read(8'h30, 16);
        for (int i = 0; i < 16; i++) begin
            if (i >= 12) exp = 8'hA1 + 8'(i - 12);
            else if (i < 2) exp = 8'hA5 + 8'(i);
            else exp = 8'hFF;
            // R4 page wrap, R9 sequential read
            chk("R4", rbuf[i], exp);
        end
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h50, a);
        send_byte(8'h77, a); chk("R5", a, 1'b1);
        bus_start();
        send_byte(8'hA0, a); chk("R5", a, 1'b1);
        send_byte(8'h50, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R5", b, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_select();
        t_byte_write();
        t_wrap();
        t_page();
        t_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule